// File: doc/BRIEF.md
# SMBus Bus Timeout Monitor

This block watches the clock and data lines of a two-wire bus and raises three timeout flags. The first flags a clock line held low too long. The second shows that the bus has gone idle, with both lines high long enough. The third flags a clock line held high while the data line stays low. A single 16-bit limit, written as two bytes, sets every threshold. The clock-low detector compares against the whole limit. The two high detectors compare against the limit shifted right by nine bits. All three count ticks of one shared time base, which runs either at the core clock or at the core clock divided by 64.

Software reaches the block through a byte-wide write port and a combinational read port. The clock-low flag and the stuck-data flag stay set until software writes a one to their bit. The idle flag is read-only and follows the bus. When its enable is set, the stuck-data flag drives an interrupt output.

Top module: `smbus_timeout_mon`

## Requirements
- R1: After reset every register reads 0 at addresses 0, 1 and 2, and `irq_o` is low. With the reset limit of 0, none of the flags ever sets.
- R2: Address 1 holds bits 15:8 of the limit and address 2 holds bits 7:0. Address 0 is control/status: bit0 tick rate, bit1 interrupt enable, bit2 clock-low flag, bit3 idle flag, bit4 stuck-data flag.
- R3: With control bit0 = 1 the counters advance every cycle. With bit0 = 0 they advance once every 64 cycles.
- R4: The lines pass through two synchronizer flops. At full tick rate with limit L, the clock-low flag sets exactly L+2 cycles after `scl_i` falls, and not earlier.
- R5: A limit of 0 disables the clock-low detector, so its flag never sets.
- R6: Writing 1 to bit2 clears the clock-low flag, and writing 0 leaves it unchanged. If a set and a clear land in the same cycle, the set wins.
- R7: The idle flag sets after both lines have been high for (limit >> 9) ticks. A threshold of 0 never sets it. It ignores writes and clears 3 cycles after either line falls.
- R8: The stuck-data flag sets after `scl_i` high and `sda_i` low have lasted (limit >> 9) ticks. At full rate that is thr+2 cycles after the change. A write of 1 to bit4 clears it, and a set wins over a clear in the same cycle.
- R9: A flag cleared while its condition persists does not set again until the condition breaks and then builds up to the threshold again.
- R10: `irq_o` is high exactly when the interrupt enable (bit1, reset 0) and the stuck-data flag are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Register read data, combinational |
| irq_o | output | 1 | Stuck-data interrupt |

## Verification
A flag can set from its detector in the same cycle that software writes a one to clear it. The bench counts the synchronizer and counter registers to find the edge where the clock-low flag and the stuck-data flag each reach their threshold. It then times a clearing write to land on exactly that edge. The flag must read 1 afterwards. A second write, one cycle later, must read back 0.

// File: rtl/smbus_tmo_pkg.sv
package smbus_tmo_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTL    = 2'd0,
    ADDR_LIM_HI = 2'd1,
    ADDR_LIM_LO = 2'd2
  } reg_addr_e;

  localparam int unsigned BIT_TICK_FULL = 0;
  localparam int unsigned BIT_IRQ_EN    = 1;
  localparam int unsigned BIT_LOW       = 2;
  localparam int unsigned BIT_FREE      = 3;
  localparam int unsigned BIT_STUCK     = 4;

  localparam int unsigned DET_LOW   = 0;
  localparam int unsigned DET_FREE  = 1;
  localparam int unsigned DET_STUCK = 2;
  localparam int unsigned NUM_DET   = 3;
endpackage

// File: rtl/smbus_tmo_sync.sv
module smbus_tmo_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  // idle bus level is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/smbus_tmo_tick.sv
module smbus_tmo_tick #(
  parameter int unsigned DIV = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic full_i,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;
  logic          wrap;

  assign wrap = (pre_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pre_q <= '0;
    else if (wrap) pre_q <= '0;
    else           pre_q <= pre_q + 1'b1;
  end

  assign tick_o = full_i | wrap;
endmodule

// File: rtl/smbus_tmo_det.sv
module smbus_tmo_det #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          cond_i,
  input  logic [CW-1:0] thr_i,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q;

  // saturates at the threshold, so the hit pulse fires once per condition episode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!cond_i)                 cnt_q <= '0;
    else if (tick_i && cnt_q < thr_i) cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = tick_i && cond_i && (thr_i != '0) && (cnt_q == thr_i - 1'b1);
endmodule

// File: rtl/smbus_timeout_mon.sv
module smbus_timeout_mon
  import smbus_tmo_pkg::*;
#(
  parameter int unsigned DIV      = 64,
  parameter int unsigned HI_SHIFT = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              irq_o
);
  localparam int unsigned LIM_W = 2 * BYTE_W;
  localparam int unsigned HI_W  = LIM_W - HI_SHIFT;

  logic [1:0]        line_s;
  logic              scl_s, sda_s;
  logic              tick;
  logic [BYTE_W-1:0] lim_hi_q, lim_lo_q;
  logic [LIM_W-1:0]  limit;
  logic [HI_W-1:0]   hi_thr;
  logic              tick_full_q, irq_en_q;
  logic              low_q, free_q, stuck_q;
  logic              wr_ctl;
  logic [NUM_DET-1:0]            cond, hit;
  logic [NUM_DET-1:0][LIM_W-1:0] thr;

  smbus_tmo_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  smbus_tmo_tick #(.DIV(DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .full_i(tick_full_q),
    .tick_o(tick)
  );

  assign limit  = {lim_hi_q, lim_lo_q};
  assign hi_thr = limit[LIM_W-1:HI_SHIFT];

  assign cond[DET_LOW]   = !scl_s;
  assign cond[DET_FREE]  = scl_s && sda_s;
  assign cond[DET_STUCK] = scl_s && !sda_s;
  assign thr[DET_LOW]    = limit;
  assign thr[DET_FREE]   = LIM_W'(hi_thr);
  assign thr[DET_STUCK]  = LIM_W'(hi_thr);

  for (genvar g = 0; g < NUM_DET; g++) begin : g_det
    smbus_tmo_det #(.CW(LIM_W)) u_det (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_i(tick),
      .cond_i(cond[g]),
      .thr_i (thr[g]),
      .hit_o (hit[g])
    );
  end

  assign wr_ctl = wr_en_i && (wr_addr_i == ADDR_CTL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_hi_q    <= '0;
      lim_lo_q    <= '0;
      tick_full_q <= 1'b0;
      irq_en_q    <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_CTL: begin
          tick_full_q <= wr_data_i[BIT_TICK_FULL];
          irq_en_q    <= wr_data_i[BIT_IRQ_EN];
        end
        ADDR_LIM_HI: lim_hi_q <= wr_data_i;
        ADDR_LIM_LO: lim_lo_q <= wr_data_i;
        default: ;
      endcase
    end
  end

  // hardware set has priority over a write-one clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q   <= 1'b0;
      stuck_q <= 1'b0;
      free_q  <= 1'b0;
    end else begin
      if (hit[DET_LOW])                          low_q <= 1'b1;
      else if (wr_ctl && wr_data_i[BIT_LOW])     low_q <= 1'b0;
      if (hit[DET_STUCK])                        stuck_q <= 1'b1;
      else if (wr_ctl && wr_data_i[BIT_STUCK])   stuck_q <= 1'b0;
      if (!cond[DET_FREE])                       free_q <= 1'b0;
      else if (hit[DET_FREE])                    free_q <= 1'b1;
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      ADDR_CTL: begin
        rd_data_o[BIT_TICK_FULL] = tick_full_q;
        rd_data_o[BIT_IRQ_EN]    = irq_en_q;
        rd_data_o[BIT_LOW]       = low_q;
        rd_data_o[BIT_FREE]      = free_q;
        rd_data_o[BIT_STUCK]     = stuck_q;
      end
      ADDR_LIM_HI: rd_data_o = lim_hi_q;
      ADDR_LIM_LO: rd_data_o = lim_lo_q;
      default:     rd_data_o = '0;
    endcase
  end

  assign irq_o = irq_en_q && stuck_q;
endmodule

// File: rtl/smbus_timeout_mon_chk.sv
module smbus_timeout_mon_chk
  import smbus_tmo_pkg::*;
#(
  parameter int unsigned LIM_W    = 16,
  parameter int unsigned HI_SHIFT = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s,
  input logic              sda_s,
  input logic [LIM_W-1:0]  limit,
  input logic              low_q,
  input logic              free_q,
  input logic              stuck_q,
  input logic              wr_ctl,
  input logic [BYTE_W-1:0] wr_data_i
);
  a_r5_zero_limit_no_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(low_q) |-> $past(limit != '0));

  a_r4_low_needs_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(low_q) |-> $past(!scl_s));

  a_r6_low_holds_without_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_q && !(wr_ctl && wr_data_i[BIT_LOW])) |=> low_q);

  a_r7_free_needs_thr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(free_q) |-> $past(limit[LIM_W-1:HI_SHIFT] != '0));

  a_r7_free_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(scl_s && sda_s) |=> !free_q);

  a_r8_stuck_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stuck_q) |-> $past(scl_s && !sda_s));

  a_r8_stuck_holds_without_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stuck_q && !(wr_ctl && wr_data_i[BIT_STUCK])) |=> stuck_q);
endmodule

bind smbus_timeout_mon smbus_timeout_mon_chk #(.LIM_W(LIM_W), .HI_SHIFT(HI_SHIFT)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_s    (scl_s),
  .sda_s    (sda_s),
  .limit    (limit),
  .low_q    (low_q),
  .free_q   (free_q),
  .stuck_q  (stuck_q),
  .wr_ctl   (wr_ctl),
  .wr_data_i(wr_data_i)
);

// File: tb/smbus_timeout_mon_bench.sv
module smbus_timeout_mon_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scl_i = 1'b1;
  logic       sda_i = 1'b1;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [1:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [7:0] CLR_LOW   = 8'h04;
  localparam logic [7:0] CLR_STUCK = 8'h10;
  localparam logic [7:0] FULL      = 8'h01;
  localparam logic [7:0] IRQ_EN    = 8'h02;

  smbus_timeout_mon u_smbus_timeout_mon (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o),
    .irq_o    (irq_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic bit exp_low(input int lim, input int hold);
    return (lim != 0) && (hold >= lim + 2);
  endfunction

  function automatic int hi_thr(input int lim);
    return lim >> 9;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr_i = a;
    #1 d = rd_data_o;
  endtask

  task automatic flags(output bit low, output bit free, output bit stuck);
    logic [7:0] d;
    rd(2'd0, d);
    low = d[2]; free = d[3]; stuck = d[4];
  endtask

  task automatic set_limit(input int v);
    wr(2'd1, 8'(v >> 8));
    wr(2'd2, 8'(v));
  endtask

  initial begin
    logic [7:0] d;
    bit lo, fr, st;
    int lim, hold, t;
    void'($urandom(32'd20240611));
    step(3);
    rst_ni = 1'b1;
    step(1);

    // R1 reset state
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), d);
      chk(d == 8'h00, "R1 reset register", d, 0);
    end
    chk(irq_o == 1'b0, "R1 reset irq", irq_o, 0);
    scl_i = 1'b0; step(300); scl_i = 1'b1; step(300);
    flags(lo, fr, st);
    chk({lo, fr, st} == 3'b000, "R1 zero limit no flags", {lo, fr, st}, 0);

    // R2 limit bytes
    set_limit(16'hA55A);
    rd(2'd1, d); chk(d == 8'hA5, "R2 limit high byte", d, 8'hA5);
    rd(2'd2, d); chk(d == 8'h5A, "R2 limit low byte", d, 8'h5A);
    wr(2'd0, FULL | IRQ_EN);
    rd(2'd0, d); chk(d[1:0] == 2'b11, "R2 control bits", d[1:0], 3);

    // R4 exact edge, full rate
    set_limit(7);
    wr(2'd0, FULL | CLR_LOW | CLR_STUCK);
    scl_i = 1'b0; step(8);
    flags(lo, fr, st); chk(lo == 1'b0, "R4 low not yet", lo, 0);
    step(1);
    flags(lo, fr, st); chk(lo == 1'b1, "R4 low at L+2", lo, 1);
    scl_i = 1'b1; step(3);

    // R6 write zero keeps, write one clears
    wr(2'd0, FULL);
    flags(lo, fr, st); chk(lo == 1'b1, "R6 write zero no effect", lo, 1);
    wr(2'd0, FULL | CLR_LOW);
    flags(lo, fr, st); chk(lo == 1'b0, "R6 write one clears", lo, 0);

    // R6 set wins over same-cycle clear
    scl_i = 1'b0; step(8);
    wr(2'd0, FULL | CLR_LOW);
    flags(lo, fr, st); chk(lo == 1'b1, "R6 set wins collision", lo, 1);
    wr(2'd0, FULL | CLR_LOW);
    flags(lo, fr, st); chk(lo == 1'b0, "R6 clear after collision", lo, 0);
    // R9 no re-set while still low
    step(20);
    flags(lo, fr, st); chk(lo == 1'b0, "R9 low stays clear", lo, 0);
    scl_i = 1'b1; step(3);

    // R5 zero limit disables
    set_limit(0);
    scl_i = 1'b0; step(200);
    flags(lo, fr, st); chk(lo == 1'b0, "R5 zero limit", lo, 0);
    scl_i = 1'b1; step(3);

    // R3 divided rate: 3 ticks need between 130 and 194 cycles
    set_limit(3);
    wr(2'd0, CLR_LOW | CLR_STUCK);
    scl_i = 1'b0; step(130);
    flags(lo, fr, st); chk(lo == 1'b0, "R3 div64 not yet", lo, 0);
    step(64);
    flags(lo, fr, st); chk(lo == 1'b1, "R3 div64 set", lo, 1);
    scl_i = 1'b1; step(3);

    // R4 random holds, full rate
    for (int i = 0; i < 30; i++) begin
      lim  = $urandom_range(1, 40);
      hold = $urandom_range(1, 60);
      set_limit(lim);
      wr(2'd0, FULL | CLR_LOW | CLR_STUCK);
      scl_i = 1'b0; step(hold);
      flags(lo, fr, st);
      chk(lo == exp_low(lim, hold), "R4 random hold", lo, exp_low(lim, hold));
      scl_i = 1'b1; step(3);
    end

    // R7 idle flag
    for (int i = 0; i < 10; i++) begin
      t = $urandom_range(1, 20);
      lim = (t << 9) | $urandom_range(0, 511);
      set_limit(lim);
      sda_i = 1'b0; step(4);
      flags(lo, fr, st); chk(fr == 1'b0, "R7 idle cleared by sda low", fr, 0);
      sda_i = 1'b1; step(hi_thr(lim) + 1);
      flags(lo, fr, st); chk(fr == 1'b0, "R7 idle not yet", fr, 0);
      step(1);
      flags(lo, fr, st); chk(fr == 1'b1, "R7 idle set", fr, 1);
      wr(2'd0, FULL | 8'h08);
      flags(lo, fr, st); chk(fr == 1'b1, "R7 idle ignores write", fr, 1);
      scl_i = 1'b0; step(2);
      flags(lo, fr, st); chk(fr == 1'b1, "R7 idle drop delay", fr, 1);
      step(1);
      flags(lo, fr, st); chk(fr == 1'b0, "R7 idle drops", fr, 0);
      scl_i = 1'b1; step(3);
    end
    set_limit(511);
    sda_i = 1'b0; step(3); sda_i = 1'b1; step(100);
    flags(lo, fr, st); chk(fr == 1'b0, "R7 zero threshold", fr, 0);

    // R8 stuck flag, R10 irq
    for (int i = 0; i < 10; i++) begin
      t = $urandom_range(1, 15);
      lim = t << 9;
      set_limit(lim);
      wr(2'd0, FULL | CLR_STUCK);
      sda_i = 1'b0; step(t + 1);
      flags(lo, fr, st); chk(st == 1'b0, "R8 stuck not yet", st, 0);
      step(1);
      flags(lo, fr, st); chk(st == 1'b1, "R8 stuck set", st, 1);
      chk(irq_o == 1'b0, "R10 irq disabled", irq_o, 0);
      wr(2'd0, FULL | IRQ_EN);
      chk(irq_o == 1'b1, "R10 irq enabled", irq_o, 1);
      wr(2'd0, FULL | IRQ_EN | CLR_STUCK);
      flags(lo, fr, st); chk(st == 1'b0, "R8 stuck cleared", st, 0);
      chk(irq_o == 1'b0, "R10 irq follows clear", irq_o, 0);
      step(t + 5);
      flags(lo, fr, st); chk(st == 1'b0, "R9 stuck no re-set", st, 0);
      sda_i = 1'b1; step(3);
      sda_i = 1'b0; step(t + 2);
      flags(lo, fr, st); chk(st == 1'b1, "R9 stuck re-arms", st, 1);
      sda_i = 1'b1; step(3);
    end

    // R8 set wins over same-cycle clear
    set_limit(4 << 9);
    wr(2'd0, FULL | CLR_STUCK);
    sda_i = 1'b0; step(5);
    wr(2'd0, FULL | CLR_STUCK);
    flags(lo, fr, st); chk(st == 1'b1, "R8 set wins collision", st, 1);
    wr(2'd0, FULL | CLR_STUCK);
    flags(lo, fr, st); chk(st == 1'b0, "R8 clear after collision", st, 0);
    sda_i = 1'b1; step(3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule